// File: doc/BRIEF.md
# Aliased Host Register Bank

This block is the byte-wide register front end of a bus-controller core. A host reaches sixteen byte slots through a synchronous strobe interface. The byte offset of slot n is n times four. Several slots are split. A host write goes to a control register that the core consumes. A host read of the same offset returns a live value that the core supplies, such as status, interrupt cause, sequence step or FIFO fill. The host therefore never reads back what it wrote at those offsets.

The bank also holds a 24-bit transfer counter. The host loads it one byte at a time through three slots. The core counts it down by one for every byte moved, and it stops at zero. The zero condition appears as bit 4 of the status byte. The slot that holds the counter's top byte is write-only for that byte. A read of that slot returns a fixed identity code, made of a 5-bit family field and a 3-bit revision field. The bank also keeps the configuration bytes, a command byte with a start pulse, and strobes for the data FIFO. It has no bus-phase or DMA logic.

Top module: `alias_reg_bank`

## Requirements
- R1: While reset is asserted and after it is released, every stored byte and the transfer count are zero, `host_rdata` is 0x00 and `count_zero` is 1.
- R2: A read (`host_rd` high at a rising edge) loads `host_rdata` at that edge with the slot's value from before the edge. `host_rdata` holds its value in cycles without a read.
- R3: Offsets 0x10, 0x14, 0x18 and 0x1C are split. Writes load `sel_bus_id`, `sel_timeout`, `sync_period` and `sync_offset` respectively. Reads return the status byte, `core_intr`, `core_step` and `core_fifo_flags` respectively.
- R4: A write to 0x00, 0x04 or 0x38 replaces count bits 7:0, 15:8 or 23:16 respectively. A read of 0x00 or 0x04 returns the current count byte. A read of 0x38 returns the identity byte {ID_FAMILY, ID_REV}, which is 0x5D by default.
- R5: With no count write in a cycle, `xfer_tick` lowers the count by one. The count stays at zero when it is already zero.
- R6: When a count-byte write and `xfer_tick` fall in the same cycle, the write takes effect. The other two bytes keep their values and no decrement happens.
- R7: The status byte is `core_status` with bit 4 replaced by 1 when the count is zero and by 0 otherwise.
- R8: 0x20, 0x2C, 0x30, 0x34 and 0x3C are read/write bytes. They drive `cfg1_q`, `cfg2_q`, `cfg3_q`, `cfg4_q` and `fifo_base`. `own_id` is `cfg1_q` bits 2:0 and `parity_en` is `cfg1_q` bit 4.
- R9: 0x24 and 0x28 are write-only and drive `clk_factor` and `test_ctrl`. Reads of these two offsets return 0x00.
- R10: A write to 0x08 raises `fifo_push` in the same cycle. A read of 0x08 raises `fifo_pop` in the same cycle and returns `fifo_rd_byte`.
- R11: A write to 0x0C loads `cmd_code`, and `cmd_start` is high for the following cycle. A read of 0x0C returns `cmd_code`.
- R12: An access whose address bits 1:0 are not zero changes no register, raises no strobe, and a read of it returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 6 | Byte offset |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| xfer_tick | input | 1 | One byte transferred by the core |
| core_status | input | 8 | Live status from the core, bit 4 ignored |
| core_intr | input | 8 | Live interrupt cause |
| core_step | input | 8 | Live sequence step |
| core_fifo_flags | input | 8 | Live FIFO flags |
| fifo_rd_byte | input | 8 | Byte at the FIFO head |
| fifo_push | output | 1 | Host writes a FIFO byte (data on host_wdata) |
| fifo_pop | output | 1 | Host reads a FIFO byte |
| cmd_code | output | 8 | Last command byte |
| cmd_start | output | 1 | One-cycle pulse after a command write |
| sel_bus_id | output | 8 | Target bus ID for selection |
| sel_timeout | output | 8 | Selection timeout |
| sync_period | output | 8 | Synchronous transfer period |
| sync_offset | output | 8 | Synchronous offset |
| cfg1_q | output | 8 | Configuration byte 1 |
| cfg2_q | output | 8 | Configuration byte 2 |
| cfg3_q | output | 8 | Configuration byte 3 |
| cfg4_q | output | 8 | Configuration byte 4 |
| clk_factor | output | 8 | Clock conversion factor |
| test_ctrl | output | 8 | Test control byte |
| fifo_base | output | 8 | FIFO base byte |
| own_id | output | 3 | Own bus ID from cfg1_q |
| parity_en | output | 1 | Parity enable from cfg1_q |
| xfer_count | output | 24 | Transfer count |
| count_zero | output | 1 | Transfer count is zero |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a host load of a count byte and a core decrement. The bench provokes it with directed writes made while `xfer_tick` is high. It then judges that the written byte lands and the other bytes keep their values without a decrement.

The second pair is a read of the status byte and a counter that reaches zero on that same edge. The bench triggers this when it counts down to zero while reading offset 0x10. It expects bit 4 to reflect the count from before the edge.

// File: rtl/hrb_pkg.sv
package hrb_pkg;

  localparam int SLOT_N    = 16;
  localparam int IDX_W     = $clog2(SLOT_N);
  localparam int ADDR_W    = IDX_W + 2;
  localparam int BYTE_W    = 8;
  localparam int CNT_BYTES = 3;
  localparam int CNT_W     = CNT_BYTES * BYTE_W;
  localparam int RB_BYTES  = 2;              // count bytes readable directly
  localparam int ZERO_BIT  = 4;              // status bit carrying count==0
  localparam int PAR_BIT   = 4;              // cfg1 parity enable
  localparam int OWN_ID_W  = 3;              // cfg1 own bus ID width

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [IDX_W-1:0] {
    SL_CNT_LO   = 4'd0,
    SL_CNT_MID  = 4'd1,
    SL_FIFO     = 4'd2,
    SL_CMD      = 4'd3,
    SL_STAT_ID  = 4'd4,
    SL_INTR_TMO = 4'd5,
    SL_STEP_PER = 4'd6,
    SL_FLG_OFS  = 4'd7,
    SL_CFG1     = 4'd8,
    SL_CLKF     = 4'd9,
    SL_TEST     = 4'd10,
    SL_CFG2     = 4'd11,
    SL_CFG3     = 4'd12,
    SL_CFG4     = 4'd13,
    SL_CNT_HI   = 4'd14,
    SL_FBASE    = 4'd15
  } slot_e;

  // slots that own a plain stored byte (write side)
  localparam logic [SLOT_N-1:0] STORE_MASK    = 16'b1011_1111_1111_1000;
  // stored slots whose byte is returned on read
  localparam logic [SLOT_N-1:0] READBACK_MASK = 16'b1011_1001_0000_1000;

  function automatic int cnt_slot(input int b);
    case (b)
      0:       return int'(SL_CNT_LO);
      1:       return int'(SL_CNT_MID);
      default: return int'(SL_CNT_HI);
    endcase
  endfunction

endpackage

// File: rtl/hrb_decode.sv
module hrb_decode
  import hrb_pkg::*;
(
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [ADDR_W-1:0] host_addr,
  output logic [SLOT_N-1:0] wr_slot,
  output logic              rd_hit,
  output logic [IDX_W-1:0]  rd_idx
);

  logic aligned;

  assign aligned = (host_addr[1:0] == 2'b00);
  assign rd_idx  = host_addr[ADDR_W-1:2];
  assign rd_hit  = host_rd & aligned;

  for (genvar i = 0; i < SLOT_N; i++) begin : g_wr
    assign wr_slot[i] = host_wr & aligned & (host_addr[ADDR_W-1:2] == IDX_W'(i));
  end

endmodule

// File: rtl/hrb_xfer_counter.sv
module hrb_xfer_counter
  import hrb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_BYTES-1:0] byte_we,
  input  byte_t                wdata,
  input  logic                 tick,
  output logic [CNT_W-1:0]     count,
  output logic                 zero
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign zero  = (cnt_q == '0);
  assign count = cnt_q;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (|byte_we) begin
      cnt_en = 1'b1;                     // host load wins over a decrement
      for (int b = 0; b < CNT_BYTES; b++) begin
        if (byte_we[b]) cnt_d[b*BYTE_W +: BYTE_W] = wdata;
      end
    end else if (tick && !zero) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/hrb_store.sv
module hrb_store
  import hrb_pkg::*;
#(
  parameter logic [SLOT_N-1:0] MASK = STORE_MASK
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [SLOT_N-1:0]      we,
  input  byte_t                  wdata,
  output logic [SLOT_N-1:0][BYTE_W-1:0] q
);

  for (genvar i = 0; i < SLOT_N; i++) begin : g_slot
    if (MASK[i]) begin : g_ff
      byte_t r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     r <= '0;
        else if (we[i]) r <= wdata;
      end
      assign q[i] = r;
    end else begin : g_none
      // strobe of this slot is consumed by other logic
      logic unused_we;
      assign unused_we = we[i];
      assign q[i]      = '0;
    end
  end

endmodule

// File: rtl/hrb_readmux.sv
module hrb_readmux
  import hrb_pkg::*;
#(
  parameter byte_t ID_BYTE = 8'h5D
) (
  input  logic [IDX_W-1:0]              rd_idx,
  input  logic                          rd_hit,
  input  logic [SLOT_N-1:0][BYTE_W-1:0] store_q,
  input  logic [RB_BYTES*BYTE_W-1:0]    count_lo,
  input  logic                          zero,
  input  byte_t                         core_status,
  input  byte_t                         core_intr,
  input  byte_t                         core_step,
  input  byte_t                         core_fifo_flags,
  input  byte_t                         fifo_rd_byte,
  output byte_t                         rd_next
);

  byte_t status_v;
  byte_t sel_v;

  assign status_v = (core_status & ~(byte_t'(1) << ZERO_BIT))
                  | (byte_t'(zero) << ZERO_BIT);

  always_comb begin
    case (slot_e'(rd_idx))
      SL_CNT_LO:   sel_v = count_lo[0 +: BYTE_W];
      SL_CNT_MID:  sel_v = count_lo[BYTE_W +: BYTE_W];
      SL_FIFO:     sel_v = fifo_rd_byte;
      SL_STAT_ID:  sel_v = status_v;
      SL_INTR_TMO: sel_v = core_intr;
      SL_STEP_PER: sel_v = core_step;
      SL_FLG_OFS:  sel_v = core_fifo_flags;
      SL_CNT_HI:   sel_v = ID_BYTE;
      default:     sel_v = READBACK_MASK[rd_idx] ? store_q[rd_idx] : '0;
    endcase
  end

  assign rd_next = rd_hit ? sel_v : '0;

endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import hrb_pkg::*;
#(
  parameter logic [4:0] ID_FAMILY = 5'h0B,
  parameter logic [2:0] ID_REV    = 3'h5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_wr,
  input  logic                 host_rd,
  input  logic [ADDR_W-1:0]    host_addr,
  input  logic [BYTE_W-1:0]    host_wdata,
  output logic [BYTE_W-1:0]    host_rdata,
  input  logic                 xfer_tick,
  input  logic [BYTE_W-1:0]    core_status,
  input  logic [BYTE_W-1:0]    core_intr,
  input  logic [BYTE_W-1:0]    core_step,
  input  logic [BYTE_W-1:0]    core_fifo_flags,
  input  logic [BYTE_W-1:0]    fifo_rd_byte,
  output logic                 fifo_push,
  output logic                 fifo_pop,
  output logic [BYTE_W-1:0]    cmd_code,
  output logic                 cmd_start,
  output logic [BYTE_W-1:0]    sel_bus_id,
  output logic [BYTE_W-1:0]    sel_timeout,
  output logic [BYTE_W-1:0]    sync_period,
  output logic [BYTE_W-1:0]    sync_offset,
  output logic [BYTE_W-1:0]    cfg1_q,
  output logic [BYTE_W-1:0]    cfg2_q,
  output logic [BYTE_W-1:0]    cfg3_q,
  output logic [BYTE_W-1:0]    cfg4_q,
  output logic [BYTE_W-1:0]    clk_factor,
  output logic [BYTE_W-1:0]    test_ctrl,
  output logic [BYTE_W-1:0]    fifo_base,
  output logic [OWN_ID_W-1:0]  own_id,
  output logic                 parity_en,
  output logic [CNT_W-1:0]     xfer_count,
  output logic                 count_zero
);

  localparam byte_t ID_BYTE = {ID_FAMILY, ID_REV};

  logic [SLOT_N-1:0]             wr_slot;
  logic                          rd_hit;
  logic [IDX_W-1:0]              rd_idx;
  logic [CNT_BYTES-1:0]          cnt_we;
  logic [SLOT_N-1:0][BYTE_W-1:0] store_q;
  byte_t                         rd_next;
  byte_t                         rdata_q;
  logic                          start_q;

  hrb_decode u_decode (
    .host_wr   (host_wr),
    .host_rd   (host_rd),
    .host_addr (host_addr),
    .wr_slot   (wr_slot),
    .rd_hit    (rd_hit),
    .rd_idx    (rd_idx)
  );

  for (genvar b = 0; b < CNT_BYTES; b++) begin : g_cnt_we
    assign cnt_we[b] = wr_slot[cnt_slot(b)];
  end

  hrb_xfer_counter u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (cnt_we),
    .wdata   (host_wdata),
    .tick    (xfer_tick),
    .count   (xfer_count),
    .zero    (count_zero)
  );

  hrb_store #(.MASK(STORE_MASK)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (wr_slot),
    .wdata (host_wdata),
    .q     (store_q)
  );

  hrb_readmux #(.ID_BYTE(ID_BYTE)) u_readmux (
    .rd_idx          (rd_idx),
    .rd_hit          (rd_hit),
    .store_q         (store_q),
    .count_lo        (xfer_count[RB_BYTES*BYTE_W-1:0]),
    .zero            (count_zero),
    .core_status     (core_status),
    .core_intr       (core_intr),
    .core_step       (core_step),
    .core_fifo_flags (core_fifo_flags),
    .fifo_rd_byte    (fifo_rd_byte),
    .rd_next         (rd_next)
  );

  // read data register: clock enable is the read strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= wr_slot[SL_CMD];
  end

  assign host_rdata  = rdata_q;
  assign cmd_start   = start_q;
  assign fifo_push   = wr_slot[SL_FIFO];
  assign fifo_pop    = rd_hit & (rd_idx == IDX_W'(SL_FIFO));

  assign cmd_code    = store_q[SL_CMD];
  assign sel_bus_id  = store_q[SL_STAT_ID];
  assign sel_timeout = store_q[SL_INTR_TMO];
  assign sync_period = store_q[SL_STEP_PER];
  assign sync_offset = store_q[SL_FLG_OFS];
  assign cfg1_q      = store_q[SL_CFG1];
  assign cfg2_q      = store_q[SL_CFG2];
  assign cfg3_q      = store_q[SL_CFG3];
  assign cfg4_q      = store_q[SL_CFG4];
  assign clk_factor  = store_q[SL_CLKF];
  assign test_ctrl   = store_q[SL_TEST];
  assign fifo_base   = store_q[SL_FBASE];
  assign own_id      = cfg1_q[OWN_ID_W-1:0];
  assign parity_en   = cfg1_q[PAR_BIT];

endmodule

// File: rtl/alias_reg_bank_chk.sv
module alias_reg_bank_chk
  import hrb_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              host_wr,
  input logic              host_rd,
  input logic [ADDR_W-1:0] host_addr,
  input logic [BYTE_W-1:0] host_wdata,
  input logic [BYTE_W-1:0] host_rdata,
  input logic              xfer_tick,
  input logic [CNT_W-1:0]  xfer_count,
  input logic              cmd_start,
  input logic [BYTE_W-1:0] cfg1_q,
  input logic [BYTE_W-1:0] sel_bus_id,
  input logic              fifo_push
);

  logic cnt_wr;
  assign cnt_wr = host_wr && (host_addr == 6'h00 || host_addr == 6'h04 || host_addr == 6'h38);

  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> $stable(host_rdata));

  a_r5_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_tick && !cnt_wr && xfer_count != '0) |=> xfer_count == $past(xfer_count) - 24'd1);

  a_r5_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_tick && !cnt_wr && xfer_count == '0) |=> xfer_count == '0);

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h00 && xfer_tick) |=> xfer_count[7:0] == $past(host_wdata));

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 6'h10) |=> host_rdata[ZERO_BIT] == $past(xfer_count == '0));

  a_r9_wo_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && (host_addr == 6'h24 || host_addr == 6'h28)) |=> host_rdata == 8'h00);

  a_r10_push: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h08) |-> fifo_push);

  a_r11_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 6'h0C) |=> cmd_start);

  a_r11_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == 6'h0C) |=> !cmd_start);

  a_r12_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr[1:0] != 2'b00) |=> ($stable(cfg1_q) && $stable(sel_bus_id)));

endmodule

bind alias_reg_bank alias_reg_bank_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .xfer_tick  (xfer_tick),
  .xfer_count (xfer_count),
  .cmd_start  (cmd_start),
  .cfg1_q     (cfg1_q),
  .sel_bus_id (sel_bus_id),
  .fifo_push  (fifo_push)
);

// File: tb/alias_reg_bank_bench.sv
`timescale 1ns/1ps
module alias_reg_bank_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b1;
  logic        host_wr = 1'b0, host_rd = 1'b0, xfer_tick = 1'b0;
  logic [5:0]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  core_status = '0, core_intr = '0, core_step = '0, core_fifo_flags = '0, fifo_rd_byte = '0;
  logic [7:0]  host_rdata, cmd_code, sel_bus_id, sel_timeout, sync_period, sync_offset;
  logic [7:0]  cfg1_q, cfg2_q, cfg3_q, cfg4_q, clk_factor, test_ctrl, fifo_base;
  logic [2:0]  own_id;
  logic        parity_en, count_zero, fifo_push, fifo_pop, cmd_start;
  logic [23:0] xfer_count;

  int checks = 0;
  int errors = 0;
  bit run = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  alias_reg_bank u_alias_reg_bank (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .xfer_tick(xfer_tick), .core_status(core_status), .core_intr(core_intr),
    .core_step(core_step), .core_fifo_flags(core_fifo_flags), .fifo_rd_byte(fifo_rd_byte),
    .fifo_push(fifo_push), .fifo_pop(fifo_pop), .cmd_code(cmd_code), .cmd_start(cmd_start),
    .sel_bus_id(sel_bus_id), .sel_timeout(sel_timeout), .sync_period(sync_period),
    .sync_offset(sync_offset), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q), .cfg3_q(cfg3_q),
    .cfg4_q(cfg4_q), .clk_factor(clk_factor), .test_ctrl(test_ctrl), .fifo_base(fifo_base),
    .own_id(own_id), .parity_en(parity_en), .xfer_count(xfer_count), .count_zero(count_zero)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] m_reg [16];
  int unsigned m_cnt;
  logic [7:0] m_rd;
  bit m_start;
  string m_rd_tag = "R2";
  string m_cnt_tag = "R5";

  task automatic model_reset();
    foreach (m_reg[i]) m_reg[i] = 8'h00;
    m_cnt = 0; m_rd = 8'h00; m_start = 1'b0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      bit ok;
      int idx;
      int unsigned nxt;
      ok  = (host_addr[1:0] == 2'b00);
      idx = int'(host_addr[5:2]);
      if (run) begin
        chk("R10 fifo_push", 32'(fifo_push), 32'(host_wr && host_addr == 6'h08));
        chk("R10 fifo_pop",  32'(fifo_pop),  32'(host_rd && host_addr == 6'h08));
      end
      if (host_rd) begin
        if (!ok) begin m_rd = 8'h00; m_rd_tag = "R12"; end
        else begin
          case (idx)
            0:  begin m_rd = 8'(m_cnt);       m_rd_tag = "R4"; end
            1:  begin m_rd = 8'(m_cnt >> 8);  m_rd_tag = "R4"; end
            2:  begin m_rd = fifo_rd_byte;    m_rd_tag = "R10"; end
            3:  begin m_rd = m_reg[3];        m_rd_tag = "R11"; end
            4:  begin m_rd = (core_status & 8'hEF) | ((m_cnt == 0) ? 8'h10 : 8'h00); m_rd_tag = "R7"; end
            5:  begin m_rd = core_intr;       m_rd_tag = "R3"; end
            6:  begin m_rd = core_step;       m_rd_tag = "R3"; end
            7:  begin m_rd = core_fifo_flags; m_rd_tag = "R3"; end
            9, 10: begin m_rd = 8'h00;        m_rd_tag = "R9"; end
            14: begin m_rd = 8'h5D;           m_rd_tag = "R4"; end
            default: begin m_rd = m_reg[idx]; m_rd_tag = "R8"; end
          endcase
        end
      end else m_rd_tag = "R2";
      nxt = m_cnt;
      if (host_wr && ok && (idx == 0 || idx == 1 || idx == 14)) begin
        if (idx == 0)  nxt = (m_cnt & 32'hFFFF00) | 32'(host_wdata);
        if (idx == 1)  nxt = (m_cnt & 32'hFF00FF) | (32'(host_wdata) << 8);
        if (idx == 14) nxt = (m_cnt & 32'h00FFFF) | (32'(host_wdata) << 16);
        m_cnt_tag = xfer_tick ? "R6" : "R4";
      end else begin
        if (xfer_tick && m_cnt != 0) nxt = m_cnt - 1;
        m_cnt_tag = "R5";
      end
      m_cnt = nxt;
      if (host_wr && ok && idx >= 3 && idx != 14) m_reg[idx] = host_wdata;
      m_start = host_wr && ok && idx == 3;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (run && rst_n) begin
      chk({m_rd_tag, " rdata"}, 32'(host_rdata), 32'(m_rd));
      chk({m_cnt_tag, " count"}, 32'(xfer_count), m_cnt);
      chk("R7 count_zero", 32'(count_zero), 32'(m_cnt == 0));
      chk("R8 own_id", 32'(own_id), 32'(m_reg[8][2:0]));
      chk("R8 parity_en", 32'(parity_en), 32'(m_reg[8][4]));
      chk("R8 cfg", {cfg1_q, cfg2_q, cfg3_q, cfg4_q}, {m_reg[8], m_reg[11], m_reg[12], m_reg[13]});
      chk("R8 fifo_base", 32'(fifo_base), 32'(m_reg[15]));
      chk("R3 select regs", {sel_bus_id, sel_timeout, sync_period, sync_offset},
          {m_reg[4], m_reg[5], m_reg[6], m_reg[7]});
      chk("R9 write-only", {16'h0, clk_factor, test_ctrl}, {16'h0, m_reg[9], m_reg[10]});
      chk("R11 cmd_code", 32'(cmd_code), 32'(m_reg[3]));
      chk("R11 cmd_start", 32'(cmd_start), 32'(m_start));
    end
  end

  task automatic op(input bit w, input bit r, input logic [5:0] a,
                    input logic [7:0] d, input bit t);
    @(negedge clk);
    host_wr = w; host_rd = r; host_addr = a; host_wdata = d; xfer_tick = t;
    core_status = 8'($urandom); core_intr = 8'($urandom);
    core_step = 8'($urandom); core_fifo_flags = 8'($urandom); fifo_rd_byte = 8'($urandom);
  endtask

  task automatic idle();
    op(1'b0, 1'b0, 6'h00, 8'h00, 1'b0);
  endtask

  // watchdog
  initial begin
    #500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state visible at the ports
    chk("R1 rdata", 32'(host_rdata), 32'h0);
    chk("R1 count", 32'(xfer_count), 32'h0);
    chk("R1 count_zero", 32'(count_zero), 32'h1);
    chk("R1 cfg1", 32'(cfg1_q), 32'h0);
    rst_n = 1'b1;
    run = 1'b1;
    idle();

    // R8: cfg1 fields
    op(1, 0, 6'h20, 8'h15, 0); idle();
    chk("R8 own_id direct", 32'(own_id), 32'h5);
    chk("R8 parity direct", 32'(parity_en), 32'h1);
    op(0, 1, 6'h20, 8'h00, 0); idle();
    chk("R8 cfg1 readback", 32'(host_rdata), 32'h15);

    // R3: write bus id at 0x10, read returns status
    op(1, 0, 6'h10, 8'h03, 0);
    op(0, 1, 6'h10, 8'h00, 0);
    core_status = 8'hA7;
    idle();
    chk("R3 0x10 read is status", 32'(host_rdata), 32'hB7);
    chk("R3 0x10 write is bus id", 32'(sel_bus_id), 32'h03);

    // R4: ID byte
    op(0, 1, 6'h38, 8'h00, 0); idle();
    chk("R4 id byte", 32'(host_rdata), 32'h5D);

    // R5: load 2, tick four times, saturates
    op(1, 0, 6'h00, 8'h02, 0);
    repeat (4) op(0, 0, 6'h00, 8'h00, 1);
    idle();
    chk("R5 saturate", 32'(xfer_count), 32'h0);

    // R7: read status on the edge the count reaches zero
    op(1, 0, 6'h00, 8'h01, 0);
    op(0, 1, 6'h10, 8'h00, 1);
    core_status = 8'h00;
    idle();
    chk("R7 status old count", 32'(host_rdata), 32'h00);
    op(0, 1, 6'h10, 8'h00, 0);
    core_status = 8'h00;
    idle();
    chk("R7 status zero", 32'(host_rdata), 32'h10);

    // R6: collision of a byte write and a tick
    op(1, 0, 6'h00, 8'h10, 0);
    op(1, 0, 6'h38, 8'h40, 0);
    op(1, 0, 6'h04, 8'h22, 1);
    idle();
    chk("R6 write wins", 32'(xfer_count), 32'h402210);
    op(1, 0, 6'h00, 8'h77, 1);
    idle();
    chk("R6 write wins lo", 32'(xfer_count), 32'h402277);

    // R12: misaligned write and read
    op(1, 0, 6'h21, 8'hFF, 0); idle();
    chk("R12 cfg1 untouched", 32'(cfg1_q), 32'h15);
    op(0, 1, 6'h22, 8'h00, 0); idle();
    chk("R12 misaligned read", 32'(host_rdata), 32'h00);

    // R9 and R11
    op(1, 0, 6'h24, 8'h06, 0);
    op(0, 1, 6'h24, 8'h00, 0); idle();
    chk("R9 clk factor read zero", 32'(host_rdata), 32'h00);
    chk("R9 clk factor out", 32'(clk_factor), 32'h06);
    op(1, 0, 6'h0C, 8'h42, 0);
    @(negedge clk);
    chk("R11 start pulse", 32'(cmd_start), 32'h1);

    // random traffic, model compared every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] a;
      a = {4'($urandom_range(0, 15)), 2'b00};
      if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom_range(1, 3));
      op(1'($urandom), 1'($urandom), a, 8'($urandom), 1'($urandom));
    end
    idle(); idle();

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule